// File: doc/BRIEF.md
# Worker Dispatcher with Decision Deadlines

This block sits at the front of a processing sub-farm and hands incoming first-level event descriptors to a pool of worker slots. An event that arrives while a slot is free and nothing is waiting goes to the lowest-numbered free slot on the next clock edge. That slot then starts a processing timer. The worker answers with a decision. If the answer comes in time, it is forwarded on a registered output stream. If the timer runs out first, a programmable default decision is forwarded instead, and any answer that comes after that is dropped and counted.

When every slot is busy, arriving events go into a first-in-first-out wait queue, and each entry is stamped with its arrival time. The oldest waiting event goes to the next slot that frees up, and its result is marked as having paid a time penalty. If that event has waited as long as the configured limit, it is thrown away and counted instead. An event that arrives while the queue is full is refused and counted. A slot becomes free again only after its result has left through the output register, so a slot never holds more than one event.

Top module: `subfarm_dispatch`

## Requirements
- R1: After reset, `asg_valid` and `out_valid` are low and `late_cnt`, `rej_cnt` and `drop_cnt` are zero.
- R2: An event that arrives while the wait queue is empty and at least one slot is free is announced on `asg_valid`/`asg_worker`/`asg_evt` one edge later. It is given to the lowest-numbered free slot.
- R3: Call the edge that issues an assignment E. A decision for that slot sampled at edge E+d with d ≤ `cfg_max_proc` is forwarded with its value, `out_dflt`=0 and the event number.
- R4: If no decision has been taken by edge E+`cfg_max_proc`+1, the result carries `cfg_dflt_dec` with `out_dflt`=1.
- R5: A decision for a slot that is not running an unexpired timer produces no output and adds one to `late_cnt`.
- R6: Events that arrive while the queue is not empty, or while no slot is free, wait in arrival order. The head goes to the lowest free slot with its result marked `out_pen`=1. Directly dispatched events have `out_pen`=0.
- R7: Call the edge that queues an event Q. If that event is still the head at edge Q+`cfg_max_wait`, it is discarded, `drop_cnt` goes up by one, and the event is never assigned.
- R8: An event that arrives while the queue holds `Q_DEPTH` entries and cannot be dispatched directly is refused, and `rej_cnt` goes up by one.
- R9: While `out_valid` is high and `out_ready` is low, all output fields hold. Results that are pending at the same time leave lowest slot first.
- R10: A slot is not reassigned until its result has been accepted into the output register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_valid | input | 1 | Event descriptor present this cycle |
| evt_id | input | EVT_W | Event number |
| asg_valid | output | 1 | Assignment pulse to a worker |
| asg_worker | output | WID_W | Slot receiving the event |
| asg_evt | output | EVT_W | Event number assigned |
| dec_valid | input | 1 | Worker decision present |
| dec_worker | input | WID_W | Slot returning the decision |
| dec_value | input | DEC_W | Decision value |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Downstream accepts result |
| out_evt | output | EVT_W | Event number of result |
| out_dec | output | DEC_W | Decision forwarded |
| out_dflt | output | 1 | Default decision used |
| out_pen | output | 1 | Event waited in queue |
| cfg_max_proc | input | TMR_W | Processing deadline in cycles |
| cfg_max_wait | input | TMR_W | Queue age limit in cycles |
| cfg_dflt_dec | input | DEC_W | Default decision value |
| late_cnt | output | CNT_W | Dropped late decisions |
| rej_cnt | output | CNT_W | Events refused on a full queue |
| drop_cnt | output | CNT_W | Events discarded for age |

## Verification
The assertions check several properties on every cycle: the output holds steady under a stall, an assignment goes only to a slot that was free, the queue level never passes its depth, and each counter moves by one and only for its own cause. Other behaviour needs directed scenarios in the bench. These include the exact edge where a decision stops being on time, the edge where a waiting event is discarded rather than dispatched, arrival-order service of the queue, and the penalty and default flags on particular results. The bench sweeps the decision delay and the release delay across those boundaries.

// File: rtl/sfd_pkg.sv
package sfd_pkg;
  typedef enum logic [1:0] {
    SLOT_IDLE = 2'd0,
    SLOT_RUN  = 2'd1,
    SLOT_HOLD = 2'd2
  } slot_state_e;
endpackage

// File: rtl/sfd_lowest_pick.sv
module sfd_lowest_pick #(
  parameter int W  = 8,
  parameter int IW = 3
) (
  input  logic [W-1:0]  req,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (req[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/sfd_wait_fifo.sv
module sfd_wait_fifo #(
  parameter int DEPTH = 16,
  parameter int EVT_W = 16,
  parameter int TMR_W = 16,
  parameter int LVL_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [EVT_W-1:0] push_evt,
  input  logic [TMR_W-1:0] push_ts,
  input  logic             pop,
  output logic             empty,
  output logic             full,
  output logic [LVL_W-1:0] level,
  output logic [EVT_W-1:0] head_evt,
  output logic [TMR_W-1:0] head_ts
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int EW = EVT_W + TMR_W;

  logic [EW-1:0] mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;

  assign empty = (level == '0);
  assign full  = (level == LVL_W'(DEPTH));
  assign {head_evt, head_ts} = mem[rd_ptr];

  // storage without reset so it maps onto RAM
  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= {push_evt, push_ts};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (push) wr_ptr <= (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (pop)  rd_ptr <= (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      if (push && !pop)      level <= level + 1'b1;
      else if (pop && !push) level <= level - 1'b1;
    end
  end
endmodule

// File: rtl/sfd_worker_slot.sv
module sfd_worker_slot
  import sfd_pkg::*;
#(
  parameter int EVT_W = 16,
  parameter int DEC_W = 8,
  parameter int TMR_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             take,
  input  logic [EVT_W-1:0] take_evt,
  input  logic             take_pen,
  input  logic             dec_hit,
  input  logic [DEC_W-1:0] dec_val,
  input  logic [TMR_W-1:0] max_proc,
  input  logic [DEC_W-1:0] dflt_dec,
  input  logic             drain,
  output logic             is_free,
  output logic             is_done,
  output logic             late,
  output logic [EVT_W-1:0] res_evt,
  output logic [DEC_W-1:0] res_dec,
  output logic             res_dflt,
  output logic             res_pen
);
  slot_state_e      st;
  logic [TMR_W-1:0] elapsed;
  logic             expired;

  assign expired = (elapsed >= max_proc);
  assign is_free = (st == SLOT_IDLE);
  assign is_done = (st == SLOT_HOLD);
  assign late    = dec_hit && ((st != SLOT_RUN) || expired);

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= SLOT_IDLE;
      elapsed  <= '0;
      res_evt  <= '0;
      res_dec  <= '0;
      res_dflt <= 1'b0;
      res_pen  <= 1'b0;
    end else begin
      unique case (st)
        SLOT_IDLE: if (take) begin
          st       <= SLOT_RUN;
          elapsed  <= '0;
          res_evt  <= take_evt;
          res_pen  <= take_pen;
        end
        SLOT_RUN: begin
          if (expired) begin
            st       <= SLOT_HOLD;
            res_dec  <= dflt_dec;
            res_dflt <= 1'b1;
          end else if (dec_hit) begin
            st       <= SLOT_HOLD;
            res_dec  <= dec_val;
            res_dflt <= 1'b0;
          end else begin
            elapsed  <= elapsed + 1'b1;
          end
        end
        SLOT_HOLD: if (drain) st <= SLOT_IDLE;
        default: st <= SLOT_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/subfarm_dispatch.sv
module subfarm_dispatch #(
  parameter int N_WORKERS = 8,
  parameter int Q_DEPTH   = 16,
  parameter int EVT_W     = 16,
  parameter int DEC_W     = 8,
  parameter int TMR_W     = 16,
  parameter int CNT_W     = 16,
  parameter int WID_W     = (N_WORKERS > 1) ? $clog2(N_WORKERS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             evt_valid,
  input  logic [EVT_W-1:0] evt_id,
  output logic             asg_valid,
  output logic [WID_W-1:0] asg_worker,
  output logic [EVT_W-1:0] asg_evt,
  input  logic             dec_valid,
  input  logic [WID_W-1:0] dec_worker,
  input  logic [DEC_W-1:0] dec_value,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [EVT_W-1:0] out_evt,
  output logic [DEC_W-1:0] out_dec,
  output logic             out_dflt,
  output logic             out_pen,
  input  logic [TMR_W-1:0] cfg_max_proc,
  input  logic [TMR_W-1:0] cfg_max_wait,
  input  logic [DEC_W-1:0] cfg_dflt_dec,
  output logic [CNT_W-1:0] late_cnt,
  output logic [CNT_W-1:0] rej_cnt,
  output logic [CNT_W-1:0] drop_cnt
);
  localparam int LVL_W = $clog2(Q_DEPTH + 1);

  logic [TMR_W-1:0] now;

  logic [N_WORKERS-1:0] slot_free, slot_done, slot_late, slot_take, slot_drain, slot_hit;
  logic [EVT_W-1:0]     slot_evt  [N_WORKERS];
  logic [DEC_W-1:0]     slot_dec  [N_WORKERS];
  logic [N_WORKERS-1:0] slot_dflt, slot_pen;

  logic             free_found, done_found;
  logic [WID_W-1:0] free_idx, done_idx;

  logic             q_empty, q_full, q_push, q_pop;
  logic [LVL_W-1:0] q_level;
  logic [EVT_W-1:0] head_evt;
  logic [TMR_W-1:0] head_ts, head_age;
  logic             head_expired, queue_go, direct_go, disp, refuse, out_load;
  logic [EVT_W-1:0] disp_evt;

  sfd_lowest_pick #(.W(N_WORKERS), .IW(WID_W)) u_free_pick (
    .req(slot_free), .found(free_found), .idx(free_idx)
  );

  sfd_lowest_pick #(.W(N_WORKERS), .IW(WID_W)) u_done_pick (
    .req(slot_done), .found(done_found), .idx(done_idx)
  );

  sfd_wait_fifo #(.DEPTH(Q_DEPTH), .EVT_W(EVT_W), .TMR_W(TMR_W), .LVL_W(LVL_W)) u_wait (
    .clk(clk), .rst(rst),
    .push(q_push), .push_evt(evt_id), .push_ts(now),
    .pop(q_pop),
    .empty(q_empty), .full(q_full), .level(q_level),
    .head_evt(head_evt), .head_ts(head_ts)
  );

  // queue head ageing and dispatch selection
  assign head_age     = now - head_ts;
  assign head_expired = !q_empty && (head_age >= cfg_max_wait);
  assign queue_go     = !q_empty && !head_expired && free_found;
  assign direct_go    = evt_valid && q_empty && free_found;
  assign disp         = queue_go || direct_go;
  assign disp_evt     = queue_go ? head_evt : evt_id;
  assign q_pop        = head_expired || queue_go;
  assign q_push       = evt_valid && !direct_go && !q_full;
  assign refuse       = evt_valid && !direct_go && q_full;
  assign out_load     = done_found && (!out_valid || out_ready);

  for (genvar g = 0; g < N_WORKERS; g++) begin : g_slot
    assign slot_take[g]  = disp && (free_idx == WID_W'(g));
    assign slot_drain[g] = out_load && (done_idx == WID_W'(g));
    assign slot_hit[g]   = dec_valid && (dec_worker == WID_W'(g));

    sfd_worker_slot #(.EVT_W(EVT_W), .DEC_W(DEC_W), .TMR_W(TMR_W)) u_slot (
      .clk(clk), .rst(rst),
      .take(slot_take[g]), .take_evt(disp_evt), .take_pen(queue_go),
      .dec_hit(slot_hit[g]), .dec_val(dec_value),
      .max_proc(cfg_max_proc), .dflt_dec(cfg_dflt_dec),
      .drain(slot_drain[g]),
      .is_free(slot_free[g]), .is_done(slot_done[g]), .late(slot_late[g]),
      .res_evt(slot_evt[g]), .res_dec(slot_dec[g]),
      .res_dflt(slot_dflt[g]), .res_pen(slot_pen[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      now        <= '0;
      asg_valid  <= 1'b0;
      asg_worker <= '0;
      asg_evt    <= '0;
      out_valid  <= 1'b0;
      out_evt    <= '0;
      out_dec    <= '0;
      out_dflt   <= 1'b0;
      out_pen    <= 1'b0;
      late_cnt   <= '0;
      rej_cnt    <= '0;
      drop_cnt   <= '0;
    end else begin
      now        <= now + 1'b1;
      asg_valid  <= disp;
      asg_worker <= free_idx;
      asg_evt    <= disp_evt;
      if (out_load) begin
        out_valid <= 1'b1;
        out_evt   <= slot_evt[done_idx];
        out_dec   <= slot_dec[done_idx];
        out_dflt  <= slot_dflt[done_idx];
        out_pen   <= slot_pen[done_idx];
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
      if (|slot_late)   late_cnt <= late_cnt + 1'b1;
      if (refuse)       rej_cnt  <= rej_cnt + 1'b1;
      if (head_expired) drop_cnt <= drop_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/sfd_dispatch_chk.sv
module sfd_dispatch_chk #(
  parameter int N_WORKERS = 8,
  parameter int Q_DEPTH   = 16,
  parameter int EVT_W     = 16,
  parameter int DEC_W     = 8,
  parameter int CNT_W     = 16,
  parameter int WID_W     = 3,
  parameter int LVL_W     = 5
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 asg_valid,
  input logic [WID_W-1:0]     asg_worker,
  input logic                 dec_valid,
  input logic                 out_valid,
  input logic                 out_ready,
  input logic [EVT_W-1:0]     out_evt,
  input logic [DEC_W-1:0]     out_dec,
  input logic                 out_dflt,
  input logic                 out_pen,
  input logic [DEC_W-1:0]     cfg_dflt_dec,
  input logic [CNT_W-1:0]     late_cnt,
  input logic [CNT_W-1:0]     rej_cnt,
  input logic [CNT_W-1:0]     drop_cnt,
  input logic [N_WORKERS-1:0] slot_free,
  input logic [LVL_W-1:0]     q_level
);
  logic [N_WORKERS-1:0] free_q;
  always_ff @(posedge clk) begin
    if (rst) free_q <= '1;
    else     free_q <= slot_free;
  end

  // R9
  out_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_evt) && $stable(out_dec)
                                   && $stable(out_dflt) && $stable(out_pen)));

  // R10
  asg_to_free_chk: assert property (@(posedge clk) disable iff (rst)
    asg_valid |-> free_q[asg_worker]);

  // R8
  q_bound_chk: assert property (@(posedge clk) disable iff (rst)
    q_level <= LVL_W'(Q_DEPTH));

  // R8
  rej_cause_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(rej_cnt) |-> ($past(q_level) == LVL_W'(Q_DEPTH) && rej_cnt == $past(rej_cnt) + 1'b1));

  // R5
  late_cause_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(late_cnt) |-> ($past(dec_valid) && late_cnt == $past(late_cnt) + 1'b1));

  // R7
  drop_cause_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(drop_cnt) |-> ($past(q_level) != '0 && drop_cnt == $past(drop_cnt) + 1'b1));

  // R4
  dflt_value_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_dflt) |-> (out_dec == cfg_dflt_dec));
endmodule

bind subfarm_dispatch sfd_dispatch_chk #(
  .N_WORKERS(N_WORKERS), .Q_DEPTH(Q_DEPTH), .EVT_W(EVT_W), .DEC_W(DEC_W),
  .CNT_W(CNT_W), .WID_W(WID_W), .LVL_W($clog2(Q_DEPTH + 1))
) u_chk (
  .clk(clk), .rst(rst), .asg_valid(asg_valid), .asg_worker(asg_worker),
  .dec_valid(dec_valid), .out_valid(out_valid), .out_ready(out_ready),
  .out_evt(out_evt), .out_dec(out_dec), .out_dflt(out_dflt), .out_pen(out_pen),
  .cfg_dflt_dec(cfg_dflt_dec), .late_cnt(late_cnt), .rej_cnt(rej_cnt),
  .drop_cnt(drop_cnt), .slot_free(slot_free), .q_level(q_level)
);

// File: tb/subfarm_dispatch_test.sv
module subfarm_dispatch_test;
  localparam int NW = 2, QD = 2, EW = 8, DW = 4, TW = 8, CW = 8, IW = 1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          evt_valid = 1'b0;
  logic [EW-1:0] evt_id = '0;
  logic          asg_valid;
  logic [IW-1:0] asg_worker;
  logic [EW-1:0] asg_evt;
  logic          dec_valid = 1'b0;
  logic [IW-1:0] dec_worker = '0;
  logic [DW-1:0] dec_value = '0;
  logic          out_valid;
  logic          out_ready = 1'b1;
  logic [EW-1:0] out_evt;
  logic [DW-1:0] out_dec;
  logic          out_dflt, out_pen;
  logic [TW-1:0] cfg_max_proc = 8'd3;
  logic [TW-1:0] cfg_max_wait = 8'd50;
  logic [DW-1:0] cfg_dflt_dec = 4'hA;
  logic [CW-1:0] late_cnt, rej_cnt, drop_cnt;

  int vectors = 0, misses = 0;
  int n_res = 0, n_asg = 0;
  int res_evt [256], res_dec [256], res_dflt [256], res_pen [256];
  int asg_w [256], asg_e [256];

  always #5 clk = ~clk;

  subfarm_dispatch #(.N_WORKERS(NW), .Q_DEPTH(QD), .EVT_W(EW), .DEC_W(DW),
                     .TMR_W(TW), .CNT_W(CW)) uut (
    .clk(clk), .rst(rst), .evt_valid(evt_valid), .evt_id(evt_id),
    .asg_valid(asg_valid), .asg_worker(asg_worker), .asg_evt(asg_evt),
    .dec_valid(dec_valid), .dec_worker(dec_worker), .dec_value(dec_value),
    .out_valid(out_valid), .out_ready(out_ready), .out_evt(out_evt),
    .out_dec(out_dec), .out_dflt(out_dflt), .out_pen(out_pen),
    .cfg_max_proc(cfg_max_proc), .cfg_max_wait(cfg_max_wait),
    .cfg_dflt_dec(cfg_dflt_dec), .late_cnt(late_cnt), .rej_cnt(rej_cnt),
    .drop_cnt(drop_cnt)
  );

  // record handshakes between edges
  always @(negedge clk) begin
    if (!rst) begin
      if (out_valid && out_ready && n_res < 256) begin
        res_evt[n_res] = int'(out_evt); res_dec[n_res] = int'(out_dec);
        res_dflt[n_res] = int'(out_dflt); res_pen[n_res] = int'(out_pen);
        n_res = n_res + 1;
      end
      if (asg_valid && n_asg < 256) begin
        asg_w[n_asg] = int'(asg_worker); asg_e[n_asg] = int'(asg_evt);
        n_asg = n_asg + 1;
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(posedge clk); #1 rst = 1'b1;
    repeat (2) @(posedge clk);
    #1 rst = 1'b0;
  endtask

  task automatic send(input int id);
    @(posedge clk); #1 evt_valid = 1'b1; evt_id = EW'(id);
    @(posedge clk); #1 evt_valid = 1'b0;
  endtask

  task automatic decide(input int w, input int v, input int d);
    repeat (d - 1) @(posedge clk);
    #1 dec_valid = 1'b1; dec_worker = IW'(w); dec_value = DW'(v);
    @(posedge clk); #1 dec_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    misses++;
    $display("FAIL watchdog R1 actual=%0d expected=%0d", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    int rb, ab;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    idle(1);
    // R1 reset state
    chk("R1 asg_valid", int'(asg_valid), 0);
    chk("R1 out_valid", int'(out_valid), 0);
    chk("R1 counters", int'(late_cnt) + int'(rej_cnt) + int'(drop_cnt), 0);

    // R3/R4 sweep of decision delay across the deadline (max_proc = 3)
    for (int d = 1; d <= 6; d++) begin
      cfg_max_proc = 8'd3; cfg_max_wait = 8'd50;
      do_reset();
      rb = n_res; ab = n_asg;
      send(d);
      decide(0, d, d);
      idle(10);
      chk("R2 lowest slot", asg_w[ab], 0);
      chk("R2 assigned evt", asg_e[ab], d);
      chk("R3/R4 result count", n_res - rb, 1);
      chk("R3/R4 evt", res_evt[rb], d);
      chk(d <= 3 ? "R3 decision" : "R4 default", res_dec[rb], d <= 3 ? d : 10);
      chk(d <= 3 ? "R3 dflt flag" : "R4 dflt flag", res_dflt[rb], d <= 3 ? 0 : 1);
      chk("R5 late count", int'(late_cnt), d <= 3 ? 0 : 1);
      chk("R6 direct no penalty", res_pen[rb], 0);
    end

    // R5 decision for an idle slot
    do_reset();
    rb = n_res;
    decide(1, 7, 1);
    idle(5);
    chk("R5 late idle slot", int'(late_cnt), 1);
    chk("R5 no output", n_res - rb, 0);

    // R6/R10 queued event waits, then gets penalty
    cfg_max_proc = 8'd100; cfg_max_wait = 8'd50;
    do_reset();
    rb = n_res; ab = n_asg;
    send(11); send(12); send(13);
    idle(4);
    chk("R10 no reassign while busy", n_asg - ab, 2);
    chk("R2 second slot", asg_w[ab + 1], 1);
    decide(1, 5, 1);
    idle(8);
    chk("R6 queued slot", asg_w[ab + 2], 1);
    chk("R6 queued evt", asg_e[ab + 2], 13);
    chk("R3 evt", res_evt[rb], 12);
    chk("R3 value", res_dec[rb], 5);
    chk("R6 direct pen", res_pen[rb], 0);
    decide(1, 6, 1);
    idle(6);
    chk("R6 queued evt result", res_evt[rb + 1], 13);
    chk("R6 penalty flag", res_pen[rb + 1], 1);

    // R8 full queue refuses; R6 arrival order
    do_reset();
    ab = n_asg;
    send(21); send(22); send(23); send(24); send(25);
    idle(2);
    chk("R8 refused", int'(rej_cnt), 1);
    decide(0, 1, 1);
    idle(5);
    decide(1, 1, 1);
    idle(5);
    chk("R6 order first", asg_e[ab + 2], 23);
    chk("R6 order first slot", asg_w[ab + 2], 0);
    chk("R6 order second", asg_e[ab + 3], 24);
    chk("R8 nothing dropped", int'(drop_cnt), 0);

    // R7 sweep: release slot 0 at edge Q+k, wait limit 5
    for (int k = 1; k <= 6; k++) begin
      cfg_max_proc = 8'd100; cfg_max_wait = 8'd5;
      do_reset();
      ab = n_asg;
      send(1); send(2); send(3);
      decide(0, 2, k);
      idle(12);
      chk("R7 drop count", int'(drop_cnt), (k + 2 < 5) ? 0 : 1);
      chk("R7 assign count", n_asg - ab, (k + 2 < 5) ? 3 : 2);
      if (k + 2 < 5) chk("R7 dispatched evt", asg_e[ab + 2], 3);
    end

    // R9 stall and lowest-first ordering
    cfg_max_proc = 8'd2; cfg_max_wait = 8'd50;
    do_reset();
    #1 out_ready = 1'b0;
    rb = n_res;
    send(31); send(32);
    idle(10);
    chk("R9 held valid", int'(out_valid), 1);
    chk("R9 first out", int'(out_evt), 31);
    idle(4);
    chk("R9 still held", int'(out_evt), 31);
    chk("R9 nothing taken", n_res - rb, 0);
    out_ready = 1'b1;
    idle(4);
    chk("R9 both out", n_res - rb, 2);
    chk("R9 order 0", res_evt[rb], 31);
    chk("R9 order 1", res_evt[rb + 1], 32);
    chk("R4 dflt both", res_dflt[rb] + res_dflt[rb + 1], 2);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule